// File: doc/BRIEF.md
# Processor Queue FIFO Pair

This block sits beside a processor core that has two dedicated queue ports. It holds two synchronous FIFOs. The ingress queue carries data toward the processor. A producer loads it through a valid/ready write port, and the processor drains it with a pop request, watching a registered empty flag. The egress queue carries data away from the processor. The processor loads it with a push request, watching a registered full flag, and a consumer drains it through a show-ahead valid/ready read port.

All transfers happen on the rising clock edge. Neither flag has a combinational path from the request that moves it. A request that would underflow or overflow a queue is dropped and touches no storage and no pointer. The processor may pop the ingress queue and push the egress queue in the same cycle. A single flush input returns both queues to the empty state. It is meant for use between data streams.

Top module: `proc_queue_pair`

## Requirements
- R1: While reset is held and in the first cycle after it: `pop_empty`=1, `pop_valid`=0, `in_wr_ready`=1, `push_full`=0 and `out_rd_valid`=0.
- R2: A pop is accepted when `pop_req`=1, `pop_empty`=0 and `flush`=0. In the next cycle `pop_valid`=1 and `pop_data` holds the oldest accepted producer word, so the words leave in write order. In every other cycle `pop_valid`=0.
- R3: A pop request while `pop_empty`=1 is ignored. `pop_valid` stays 0 in the next cycle, and the later pop data sequence is unchanged.
- R4: A push request while `push_full`=1 is ignored. The consumer later reads exactly the previously accepted words, in order.
- R5: Each flag is a register. When a pop removes the last ingress word, `pop_empty` goes to 1 in the cycle after that edge. When a push fills the last egress slot, `push_full` goes to 1 in the cycle after that edge. `pop_empty` rises only after a pop or a flush, and `push_full` rises only after a push.
- R6: A producer write into an empty ingress queue clears `pop_empty` in the next cycle.
- R7: `in_wr_ready` is 1 exactly when the ingress queue holds fewer than DEPTH words. A write offered while it is 0 is dropped.
- R8: `out_rd_valid` is 1 exactly when the egress queue is non-empty, and `out_rd_data` then shows the oldest word. A read takes effect only when `out_rd_valid`=1 and `out_rd_ready`=1.
- R9: When `flush`=1 at an edge, both queues are empty after that edge: `pop_empty`=1, `push_full`=0, `in_wr_ready`=1, `out_rd_valid`=0 and `pop_valid`=0. Every request made in that cycle is ignored.
- R10: A pop and a push made in the same cycle, both allowed, both take effect.
- R11: On a queue that is neither empty nor full, a write and a read in the same cycle leave the occupancy and both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transfers happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties both queues at the next edge |
| in_wr_valid | input | 1 | Producer offers a word to the ingress queue |
| in_wr_data | input | DATA_W | Producer word |
| in_wr_ready | output | 1 | Ingress queue can take a word |
| pop_req | input | 1 | Processor pop request |
| pop_empty | output | 1 | Registered ingress-empty flag |
| pop_data | output | DATA_W | Popped word, registered |
| pop_valid | output | 1 | `pop_data` holds a word popped at the previous edge |
| push_req | input | 1 | Processor push request |
| push_data | input | DATA_W | Word to push |
| push_full | output | 1 | Registered egress-full flag |
| out_rd_valid | output | 1 | Egress queue has a word for the consumer |
| out_rd_data | output | DATA_W | Oldest egress word (show-ahead) |
| out_rd_ready | input | 1 | Consumer takes the shown word |

## Verification
The assertions assume that every input has a known value on each rising edge after reset, and that a flush may occur at any time. They assume nothing about the data or about how often requests come. They never require a request to be withheld while a queue is empty or full, because the block must drop such requests on its own. The stimulus changes inputs only on falling edges. It sweeps request mixes from an LFSR through phases that favour producers, then consumers, so that both queues spend long spells full and empty while requests keep arriving. Flush pulses are spread across these phases.

// File: rtl/qpair_pkg.sv
package qpair_pkg;

  function automatic int unsigned ptr_mask(int unsigned pw);
    return (32'd1 << pw) - 32'd1;
  endfunction

  // advance a wrap-bit pointer by one when enabled
  function automatic int unsigned ptr_step(int unsigned ptr, bit adv, int unsigned pw);
    return (ptr + (adv ? 32'd1 : 32'd0)) & ptr_mask(pw);
  endfunction

  // words held, from write and read pointers that carry one wrap bit
  function automatic int unsigned fill_level(int unsigned wr, int unsigned rd, int unsigned pw);
    return (wr - rd) & ptr_mask(pw);
  endfunction

endpackage

// File: rtl/qpair_store.sv
module qpair_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/qpair_ptrs.sv
module qpair_ptrs
  import qpair_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          full,
  output logic          empty
);

  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          full_q, empty_q;
  int unsigned   level_nxt;

  // requests are qualified only by registered flags
  assign wr_acc = wr_req & ~full_q  & ~flush;
  assign rd_acc = rd_req & ~empty_q & ~flush;

  always_comb begin
    if (flush) begin
      wr_nxt = '0;
      rd_nxt = '0;
    end else begin
      wr_nxt = PW'(ptr_step(32'(wr_ptr), wr_acc, PW));
      rd_nxt = PW'(ptr_step(32'(rd_ptr), rd_acc, PW));
    end
    level_nxt = fill_level(32'(wr_nxt), 32'(rd_nxt), PW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      wr_ptr  <= wr_nxt;
      rd_ptr  <= rd_nxt;
      empty_q <= (level_nxt == 0);
      full_q  <= (level_nxt == 32'(DEPTH));
    end
  end

  assign wr_addr = wr_ptr[AW-1:0];
  assign rd_addr = rd_ptr[AW-1:0];
  assign full    = full_q;
  assign empty   = empty_q;

endmodule

// File: rtl/qpair_fifo.sv
module qpair_fifo #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 8,
  parameter bit SHOW_AHEAD = 1'b0,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_req,
  output logic              empty,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              wr_acc,
  output logic              rd_acc
);

  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DATA_W-1:0] head_word;

  qpair_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .wr_acc  (wr_acc),
    .rd_acc  (rd_acc),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .full    (full),
    .empty   (empty)
  );

  qpair_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_acc),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (head_word)
  );

  generate
    if (SHOW_AHEAD) begin : g_show
      // head word is visible before the read
      assign rd_data  = head_word;
      assign rd_valid = ~empty;
    end else begin : g_reg
      logic [DATA_W-1:0] data_q;
      logic              valid_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q  <= '0;
          valid_q <= 1'b0;
        end else begin
          valid_q <= rd_acc;
          if (rd_acc) data_q <= head_word;
        end
      end
      assign rd_data  = data_q;
      assign rd_valid = valid_q;
    end
  endgenerate

endmodule

// File: rtl/proc_queue_pair.sv
module proc_queue_pair #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_wr_valid,
  input  logic [DATA_W-1:0] in_wr_data,
  output logic              in_wr_ready,
  input  logic              pop_req,
  output logic              pop_empty,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_full,
  output logic              out_rd_valid,
  output logic [DATA_W-1:0] out_rd_data,
  input  logic              out_rd_ready
);

  // named internal events, observed by the bound checker
  logic in_full, out_empty;
  logic in_wr_accept, pop_accept, push_accept, out_rd_accept;

  qpair_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SHOW_AHEAD(1'b0)) u_ingress (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_req   (in_wr_valid),
    .wr_data  (in_wr_data),
    .full     (in_full),
    .rd_req   (pop_req),
    .empty    (pop_empty),
    .rd_data  (pop_data),
    .rd_valid (pop_valid),
    .wr_acc   (in_wr_accept),
    .rd_acc   (pop_accept)
  );

  qpair_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SHOW_AHEAD(1'b1)) u_egress (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_req   (push_req),
    .wr_data  (push_data),
    .full     (push_full),
    .rd_req   (out_rd_ready),
    .empty    (out_empty),
    .rd_data  (out_rd_data),
    .rd_valid (out_rd_valid),
    .wr_acc   (push_accept),
    .rd_acc   (out_rd_accept)
  );

  assign in_wr_ready = ~in_full;

endmodule

// File: rtl/qpair_checker.sv
module qpair_checker (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic in_wr_valid,
  input logic in_wr_ready,
  input logic pop_req,
  input logic pop_empty,
  input logic pop_valid,
  input logic push_req,
  input logic push_full,
  input logic out_rd_valid,
  input logic out_rd_ready,
  input logic pop_accept,
  input logic push_accept,
  input logic in_wr_accept,
  input logic out_rd_accept
);

  a_r2_pop_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pop_accept |=> pop_valid);

  a_r3_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && pop_empty) |=> !pop_valid);

  a_r4_full_holds_on_push: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && push_full && !flush && !out_rd_accept) |=> push_full);

  a_r5_empty_rise_by_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pop_empty) |-> ($past(pop_accept) || $past(flush)));

  a_r5_full_rise_by_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_full) |-> $past(push_accept));

  a_r7_ingress_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr_valid && !in_wr_ready && !pop_req && !flush) |=> !in_wr_ready);

  a_r8_no_read_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rd_ready && !out_rd_valid && !push_req && !flush) |=> !out_rd_valid);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pop_empty && !push_full && in_wr_ready && !out_rd_valid && !pop_valid));

  a_r9_flush_blocks_requests: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(pop_accept || push_accept || in_wr_accept || out_rd_accept));

  a_r10_dual_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !pop_empty && push_req && !push_full && !flush) |-> (pop_accept && push_accept));

endmodule

bind proc_queue_pair qpair_checker u_qpair_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .in_wr_valid   (in_wr_valid),
  .in_wr_ready   (in_wr_ready),
  .pop_req       (pop_req),
  .pop_empty     (pop_empty),
  .pop_valid     (pop_valid),
  .push_req      (push_req),
  .push_full     (push_full),
  .out_rd_valid  (out_rd_valid),
  .out_rd_ready  (out_rd_ready),
  .pop_accept    (pop_accept),
  .push_accept   (push_accept),
  .in_wr_accept  (in_wr_accept),
  .out_rd_accept (out_rd_accept)
);

// File: tb/proc_queue_pair_bench.sv
module proc_queue_pair_bench;

  localparam int DW = 32;
  localparam int D  = 4;

  logic          clk = 1'b0;
  logic          rst_n, flush;
  logic          in_wr_valid, pop_req, push_req, out_rd_ready;
  logic [DW-1:0] in_wr_data, push_data;
  logic          in_wr_ready, pop_empty, pop_valid, push_full, out_rd_valid;
  logic [DW-1:0] pop_data, out_rd_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  proc_queue_pair #(.DATA_W(DW), .DEPTH(D)) u_proc_queue_pair (
    .clk, .rst_n, .flush,
    .in_wr_valid, .in_wr_data, .in_wr_ready,
    .pop_req, .pop_empty, .pop_data, .pop_valid,
    .push_req, .push_data, .push_full,
    .out_rd_valid, .out_rd_data, .out_rd_ready
  );

  // reference queues
  logic [DW-1:0] in_q[$];
  logic [DW-1:0] out_q[$];
  logic          exp_pv;
  logic [DW-1:0] exp_pd;
  string         tag_empty, tag_ready, tag_pv, tag_full, tag_out;

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(pop_empty === (in_q.size() == 0), tag_empty, "pop_empty", 32'(pop_empty), 32'(in_q.size() == 0));
    chk(in_wr_ready === (in_q.size() < D), tag_ready, "in_wr_ready", 32'(in_wr_ready), 32'(in_q.size() < D));
    chk(pop_valid === exp_pv, tag_pv, "pop_valid", 32'(pop_valid), 32'(exp_pv));
    if (exp_pv) chk(pop_data === exp_pd, tag_pv, "pop_data", pop_data, exp_pd);
    chk(push_full === (out_q.size() == D), tag_full, "push_full", 32'(push_full), 32'(out_q.size() == D));
    chk(out_rd_valid === (out_q.size() > 0), "R8", "out_rd_valid", 32'(out_rd_valid), 32'(out_q.size() > 0));
    if (out_q.size() > 0) chk(out_rd_data === out_q[0], tag_out, "out_rd_data", out_rd_data, out_q[0]);
  endtask

  // apply one cycle of inputs and advance the model to its post-edge state
  task automatic step_model(bit f, bit iv, logic [DW-1:0] id, bit pp, bit ps, logic [DW-1:0] pd, bit ordy);
    bit wa, pa, sa, ra;
    int nin, nout;
    flush = f; in_wr_valid = iv; in_wr_data = id; pop_req = pp;
    push_req = ps; push_data = pd; out_rd_ready = ordy;
    nin = in_q.size(); nout = out_q.size();
    tag_empty = "R5"; tag_ready = "R7"; tag_pv = "R2"; tag_full = "R5"; tag_out = "R8";
    if (f) begin
      in_q.delete(); out_q.delete(); exp_pv = 1'b0;
      tag_empty = "R9"; tag_ready = "R9"; tag_pv = "R9"; tag_full = "R9";
      return;
    end
    wa = iv && nin < D;
    pa = pp && nin > 0;
    sa = ps && nout < D;
    ra = ordy && nout > 0;
    if (pp && nin == 0) tag_pv = "R3";
    if (pa && sa) tag_pv = "R10";
    if (wa && nin == 0 && !pa) tag_empty = "R6";
    if (wa && pa) begin tag_empty = "R11"; tag_ready = "R11"; end
    if (sa && ra) tag_full = "R11";
    if (ps && nout == D) tag_out = "R4";
    exp_pv = pa;
    if (pa) exp_pd = in_q.pop_front();
    if (wa) in_q.push_back(id);
    if (ra) void'(out_q.pop_front());
    if (sa) out_q.push_back(pd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; flush = 0; in_wr_valid = 0; pop_req = 0; push_req = 0; out_rd_ready = 0;
    in_wr_data = '0; push_data = '0;
    exp_pv = 0; exp_pd = '0;
    repeat (3) @(negedge clk);
    // R1: values while reset is still held
    chk(pop_empty === 1'b1 && pop_valid === 1'b0, "R1", "ingress reset", {30'd0, pop_empty, pop_valid}, 32'd2);
    chk(in_wr_ready === 1'b1, "R1", "in_wr_ready reset", 32'(in_wr_ready), 32'd1);
    chk(push_full === 1'b0 && out_rd_valid === 1'b0, "R1", "egress reset", {30'd0, push_full, out_rd_valid}, 32'd0);
    rst_n = 1'b1;
    // R1: first cycle after release
    step_model(0, 0, '0, 0, 0, '0, 0);
    @(negedge clk);
    tag_empty = "R1"; tag_ready = "R1"; tag_pv = "R1"; tag_full = "R1";
    compare_all();

    // directed: pop and read with both queues empty (R3, R8)
    step_model(0, 0, '0, 1, 0, '0, 1); @(negedge clk); compare_all();
    // fill the ingress queue past its depth, then drain past empty (R4, R5, R7)
    for (int k = 0; k < D + 2; k++) begin
      step_model(0, 1, 32'hA000_0000 + 32'(k), 0, 1, 32'hB000_0000 + 32'(k), 0);
      @(negedge clk); compare_all();
    end
    for (int k = 0; k < D + 2; k++) begin
      step_model(0, 0, '0, 1, 0, '0, 1);
      @(negedge clk); compare_all();
    end

    // swept mixes: producer-heavy, consumer-heavy and balanced phases
    r = 32'h1ACE_B00C;
    for (int c = 1; c <= 4000; c++) begin
      int ph;
      bit iv, pp, ps, ordy, f;
      r  = {r[30:0], 1'b0} ^ (r[31] ? 32'h04C1_1DB7 : 32'h0);
      ph = (c >> 7) & 3;
      case (ph)
        1:       begin iv = r[0] | r[1]; pp = r[2] & r[3]; ps = r[4] | r[5]; ordy = r[6] & r[7]; end
        2:       begin iv = r[0] & r[1]; pp = r[2] | r[3]; ps = r[4] & r[5]; ordy = r[6] | r[7]; end
        default: begin iv = r[0];        pp = r[2];        ps = r[4];        ordy = r[6];        end
      endcase
      f = (c % 113) == 0;
      step_model(f, iv, {16'(c), r[31:16]}, pp, ps, {r[15:0], 16'(c)}, ordy);
      @(negedge clk);
      compare_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule